// File: doc/BRIEF.md
# Flash Sector Address Generator

This block turns the address set-up that software leaves in a flash controller into the numbers the data mover needs. It holds eight 16-bit start-address registers and a start-buffer register. From them it forms a linear 512-byte sector index for the source of a transfer, a second index for the destination of a copy-back, and the first sector of the 128 KB erase block that the source block register names. The flash layout is fixed: pages of 2 KB, four sectors to a page, and 64 pages to a block. The start-buffer register also yields a sector count, from 1 to 4, and a buffer selection. The selection picks the boot buffer or one of two data buffers, plus a byte offset into the main or spare area of that buffer.

A high-density part uses bit 15 of a block register as an extension flag. When the flag is set, the parameter `DENS_MASK` is ORed into the 12-bit block number. The controller pulses `calc`, and on the next cycle the registered results appear together with a one-cycle `out_valid`. That output is a valid-only stream with no ready. The consumer has no means of back-pressure and must take the results in the cycle `out_valid` is high. The results stay on the pins until the next `calc`. After each boot-area page load, a `page_adv` pulse moves the source page register on by one page.

Top module: `flash_sector_addr_gen`

## Requirements
- R1: After reset, all eight start-address registers read 0, the start-buffer register reads 0 (buffer address 0, count 1), and `out_valid` is 0.
- R2: A write with `wr_idx` 0 to 7 stores all 16 bits of `wr_data` in that start-address register, and `rd_data` returns it while `rd_idx` selects it.
- R3: A write with `wr_idx` 8 sets the buffer address to `wr_data[11:8]` and the sector count to `wr_data[1:0]`, where code 0 means 4. The other bits are dropped. Reading index 8 returns the buffer address in bits 11:8, OR 2 when (count-1) has bit 1 set, and 0 in every other bit.
- R4: The source sector is the block field of register 0 times 256, plus bits 7:0 of register 7. The block field is register 0 bits 11:0, ORed with `DENS_MASK` when bit 15 is 1. Bits 14:12 of the block register and bits 15:8 of the page register have no effect.
- R5: The destination sector uses the same rule, with register 2 as block and register 3 as page.
- R6: The erase base sector is the block field of register 0 times 256, which is the first of its 256 sectors.
- R7: A `calc` sampled at a clock edge loads all outputs from the register values held before that edge. `out_valid` is high for exactly the following cycle, and the outputs do not change without `calc`.
- R8: `buf_is_data` is buffer address bit 3, and `buf_bank` is bit 2. `main_off` is bits 1:0 times 512, `spare_off` is bits 1:0 times 16, and `sec_count` is the count (1 to 4). All are registered by `calc`.
- R9: A `page_adv` pulse sets register 7 to ((bits 7:0) + 4) mod 256 and clears bits 15:8. A write to register 7 in the same cycle takes priority.
- R10: Writes with `wr_idx` 9 to 15 change no register, and reads of those indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index written (0-7 start address, 8 start buffer) |
| wr_data | input | 16 | Write value |
| rd_idx | input | 4 | Register index read |
| rd_data | output | 16 | Read value of `rd_idx` (combinational) |
| page_adv | input | 1 | Advance the source page after a boot-area page load |
| calc | input | 1 | Compute strobe |
| out_valid | output | 1 | Results valid, one cycle after `calc` |
| src_sector | output | BF_W+8 | Source sector index |
| dst_sector | output | BF_W+8 | Copy-back destination sector index |
| erase_sector | output | BF_W+8 | First sector of the source block |
| sec_count | output | 3 | Sector count 1 to 4 |
| buf_is_data | output | 1 | 1 selects a data buffer, 0 the boot buffer |
| buf_bank | output | 1 | Which of the two data buffers |
| main_off | output | 11 | Byte offset into the main area |
| spare_off | output | 6 | Byte offset into the spare area |

## Verification
The bench uses the default build: a 14-bit block field and `DENS_MASK` = 0x1000. Bit 15 therefore forces a bit just above the 12-bit block number, so every flagged block shows up as a distinct sector range. With this small configuration the bench covers all 64 codes of the start-buffer register, all 256 page values, and 64 block patterns with and without the extension flag and with junk in the ignored bits. It also runs the page advance through its 8-bit wrap.

// File: rtl/fsag_pkg.sv
package fsag_pkg;
  localparam int          REG_W      = 16;
  localparam int          NUM_AREGS  = 8;
  localparam int          BLK_LOW_W  = 12;
  localparam int          PAGE_LOW_W = 8;
  localparam int          PAGE_STEP  = 4;
  localparam int          MAX_COUNT  = 4;
  localparam logic [3:0]  IDX_SRC_BLK = 4'd0;
  localparam logic [3:0]  IDX_DST_BLK = 4'd2;
  localparam logic [3:0]  IDX_DST_PG  = 4'd3;
  localparam logic [3:0]  IDX_SRC_PG  = 4'd7;
  localparam logic [3:0]  IDX_BUF     = 4'd8;
endpackage

// File: rtl/fsag_regs.sv
module fsag_regs
  import fsag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [3:0]       rd_idx,
  input  logic             page_adv,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] src_blk,
  output logic [REG_W-1:0] src_pg,
  output logic [REG_W-1:0] dst_blk,
  output logic [REG_W-1:0] dst_pg,
  output logic [3:0]       buf_addr,
  output logic [2:0]       sec_cnt
);
  logic [REG_W-1:0] areg [NUM_AREGS];
  logic [2:0]       cnt_m1;
  logic [7:0]       src_pg_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_AREGS; i++) areg[i] <= '0;
      buf_addr <= '0;
      sec_cnt  <= 3'd1;
    end else begin
      for (int i = 0; i < NUM_AREGS; i++) begin
        if (wr_en && wr_idx == 4'(i))
          areg[i] <= wr_data;
        else if (page_adv && 4'(i) == IDX_SRC_PG)
          areg[i] <= {8'h00, areg[i][7:0] + 8'(PAGE_STEP)};
      end
      if (wr_en && wr_idx == IDX_BUF) begin
        buf_addr <= wr_data[11:8];
        sec_cnt  <= (wr_data[1:0] == 2'd0) ? 3'(MAX_COUNT) : {1'b0, wr_data[1:0]};
      end
    end
  end

  assign cnt_m1    = sec_cnt - 3'd1;
  assign src_pg_lo = areg[IDX_SRC_PG[2:0]][7:0];

  always_comb begin
    rd_data = '0;
    if (rd_idx < 4'(NUM_AREGS))
      rd_data = areg[rd_idx[2:0]];
    else if (rd_idx == IDX_BUF)
      rd_data = {4'h0, buf_addr, 6'h00, cnt_m1[1], 1'b0};
  end

  assign src_blk = areg[IDX_SRC_BLK[2:0]];
  assign src_pg  = areg[IDX_SRC_PG[2:0]];
  assign dst_blk = areg[IDX_DST_BLK[2:0]];
  assign dst_pg  = areg[IDX_DST_PG[2:0]];

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_cnt != 3'd0) && (sec_cnt <= 3'(MAX_COUNT)));

  // R9
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_adv && !(wr_en && wr_idx == IDX_SRC_PG)) |=>
      (src_pg[7:0] == 8'($past(src_pg_lo) + 8'(PAGE_STEP))) && (src_pg[15:8] == 8'h00));
endmodule

// File: rtl/fsag_sector_calc.sv
module fsag_sector_calc
  import fsag_pkg::*;
#(
  parameter int               BF_W      = 14,
  parameter logic [BF_W-1:0]  DENS_MASK = '0,
  localparam int              SW        = BF_W + PAGE_LOW_W
)(
  input  logic [REG_W-1:0] blk,
  input  logic [REG_W-1:0] pg,
  output logic [BF_W-1:0]  blk_field,
  output logic [SW-1:0]    sector
);
  assign blk_field = BF_W'(blk[BLK_LOW_W-1:0]) | (blk[REG_W-1] ? DENS_MASK : '0);
  assign sector    = {blk_field, pg[PAGE_LOW_W-1:0]};
endmodule

// File: rtl/flash_sector_addr_gen.sv
module flash_sector_addr_gen
  import fsag_pkg::*;
#(
  parameter int              BF_W      = 14,
  parameter logic [BF_W-1:0] DENS_MASK = 14'h1000,
  localparam int             SW        = BF_W + PAGE_LOW_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_idx,
  input  logic [15:0]      wr_data,
  input  logic [3:0]       rd_idx,
  output logic [15:0]      rd_data,
  input  logic             page_adv,
  input  logic             calc,
  output logic             out_valid,
  output logic [SW-1:0]    src_sector,
  output logic [SW-1:0]    dst_sector,
  output logic [SW-1:0]    erase_sector,
  output logic [2:0]       sec_count,
  output logic             buf_is_data,
  output logic             buf_bank,
  output logic [10:0]      main_off,
  output logic [5:0]       spare_off
);
  logic [REG_W-1:0] blk_v [2];
  logic [REG_W-1:0] pg_v  [2];
  logic [BF_W-1:0]  bf_v  [2];
  logic [SW-1:0]    sec_v [2];
  logic [3:0]       buf_addr;
  logic [2:0]       sec_cnt;

  fsag_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .page_adv(page_adv), .rd_data(rd_data),
    .src_blk(blk_v[0]), .src_pg(pg_v[0]), .dst_blk(blk_v[1]), .dst_pg(pg_v[1]),
    .buf_addr(buf_addr), .sec_cnt(sec_cnt)
  );

  for (genvar k = 0; k < 2; k++) begin : g_calc
    fsag_sector_calc #(.BF_W(BF_W), .DENS_MASK(DENS_MASK)) u_calc (
      .blk(blk_v[k]), .pg(pg_v[k]), .blk_field(bf_v[k]), .sector(sec_v[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      src_sector   <= '0;
      dst_sector   <= '0;
      erase_sector <= '0;
      sec_count    <= 3'd1;
      buf_is_data  <= 1'b0;
      buf_bank     <= 1'b0;
      main_off     <= '0;
      spare_off    <= '0;
    end else begin
      out_valid <= calc;
      if (calc) begin
        src_sector   <= sec_v[0];
        dst_sector   <= sec_v[1];
        erase_sector <= {bf_v[0], {PAGE_LOW_W{1'b0}}};
        sec_count    <= sec_cnt;
        buf_is_data  <= buf_addr[3];
        buf_bank     <= buf_addr[2];
        main_off     <= {buf_addr[1:0], 9'h000};
        spare_off    <= {buf_addr[1:0], 4'h0};
      end
    end
  end

  // R7
  calc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    calc |=> out_valid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !calc |=> ($stable(src_sector) && $stable(dst_sector) && $stable(erase_sector)
               && $stable(sec_count) && !out_valid));

  // R6
  erase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (erase_sector[SW-1:PAGE_LOW_W] == src_sector[SW-1:PAGE_LOW_W])
                  && (erase_sector[PAGE_LOW_W-1:0] == '0));
endmodule

// File: tb/sim_flash_sector_addr_gen.sv
module sim_flash_sector_addr_gen;
  localparam int BF_W = 14;
  localparam int SW   = BF_W + 8;
  localparam longint MASK = 64'h1000;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, page_adv = 0, calc = 0;
  logic [3:0] wr_idx = 0, rd_idx = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic out_valid, buf_is_data, buf_bank;
  logic [SW-1:0] src_sector, dst_sector, erase_sector;
  logic [2:0] sec_count;
  logic [10:0] main_off;
  logic [5:0] spare_off;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  flash_sector_addr_gen u0 (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [15:0] v);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [3:0] idx, input longint exp, input string req);
    rd_idx = idx; #1;
    chk(rd_data == 16'(exp), req, rd_data, exp);
  endtask

  task automatic do_calc();
    @(negedge clk); calc = 1;
    @(negedge clk); calc = 0;
  endtask

  function automatic longint bfield(input longint b);
    return (b & 64'hfff) | (((b >> 15) & 1) != 0 ? MASK : 0);
  endfunction

  function automatic longint sect(input longint b, input longint p);
    return (bfield(b) << 8) + (p & 64'hff);
  endfunction

  initial begin
    longint m [8];
    #22 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1", out_valid, 0);
    for (int i = 0; i <= 8; i++) rd_chk(4'(i), 0, "R1");

    // R2 read/write of each start-address register
    for (int i = 0; i < 8; i++) begin
      m[i] = (64'hA5C3 ^ (i * 64'h1111)) & 64'hffff;
      wr(4'(i), 16'(m[i]));
    end
    for (int i = 0; i < 8; i++) rd_chk(4'(i), m[i], "R2");

    // R10 unused indices
    for (int i = 9; i < 16; i++) wr(4'(i), 16'hffff);
    for (int i = 9; i < 16; i++) rd_chk(4'(i), 0, "R10");
    for (int i = 0; i < 8; i++) rd_chk(4'(i), m[i], "R10");
    rd_chk(4'd8, 0, "R10");

    // R3 / R8 all start-buffer codes, with junk in dropped bits
    for (int v = 0; v < 64; v++) begin
      longint ba, cnt, exp_rd;
      ba = (v >> 2) & 15;
      cnt = ((v & 3) == 0) ? 4 : (v & 3);
      wr(4'd8, 16'((ba << 8) | (v & 3) | 64'hF0FC));
      exp_rd = (ba << 8) | ((cnt - 1) & 2);
      rd_chk(4'd8, exp_rd, "R3");
      do_calc();
      chk(out_valid == 1, "R7", out_valid, 1);
      chk(sec_count == 3'(cnt), "R3", sec_count, cnt);
      chk(buf_is_data == ba[3] && buf_bank == ba[2], "R8",
          {buf_is_data, buf_bank}, (ba >> 2) & 3);
      chk(main_off == 11'((ba & 3) * 512), "R8", main_off, (ba & 3) * 512);
      chk(spare_off == 6'((ba & 3) * 16), "R8", spare_off, (ba & 3) * 16);
    end

    // R4 / R5 / R6 block patterns
    for (int k = 0; k < 64; k++) begin
      longint sb, sp, db, dp;
      sb = ((k * 67) & 64'hfff) | ((k & 1) != 0 ? 64'h8000 : 0) | ((k & 2) != 0 ? 64'h7000 : 0);
      sp = ((k * 5) & 64'hff) | 64'hAB00;
      db = ((k * 131 + 7) & 64'hfff) | ((k & 4) != 0 ? 64'h8000 : 0) | ((k & 8) != 0 ? 64'h5000 : 0);
      dp = ((k * 11 + 3) & 64'hff) | 64'h3400;
      wr(4'd0, 16'(sb)); wr(4'd7, 16'(sp)); wr(4'd2, 16'(db)); wr(4'd3, 16'(dp));
      do_calc();
      chk(src_sector == SW'(sect(sb, sp)), "R4", src_sector, sect(sb, sp));
      chk(dst_sector == SW'(sect(db, dp)), "R5", dst_sector, sect(db, dp));
      chk(erase_sector == SW'(bfield(sb) << 8), "R6", erase_sector, bfield(sb) << 8);
    end

    // R4 full page sweep
    wr(4'd0, 16'h8ABC);
    for (int p = 0; p < 256; p++) begin
      wr(4'd7, 16'(p | 64'hFF00));
      do_calc();
      chk(src_sector == SW'(sect(64'h8ABC, p)), "R4", src_sector, sect(64'h8ABC, p));
    end

    // R7 hold without calc, and calc samples pre-edge values
    @(negedge clk);
    chk(out_valid == 0, "R7", out_valid, 0);
    wr(4'd7, 16'h0011);
    @(negedge clk);
    chk(src_sector == SW'(sect(64'h8ABC, 255)), "R7", src_sector, sect(64'h8ABC, 255));
    @(negedge clk); calc = 1; wr_en = 1; wr_idx = 4'd7; wr_data = 16'h0022;
    @(negedge clk); calc = 0; wr_en = 0;
    chk(src_sector == SW'(sect(64'h8ABC, 64'h11)), "R7", src_sector, sect(64'h8ABC, 64'h11));
    do_calc();
    chk(src_sector == SW'(sect(64'h8ABC, 64'h22)), "R7", src_sector, sect(64'h8ABC, 64'h22));

    // R9 page advance with wrap
    wr(4'd7, 16'h12F0);
    for (int s = 1; s <= 70; s++) begin
      @(negedge clk); page_adv = 1;
      @(negedge clk); page_adv = 0;
      rd_chk(4'd7, (64'hF0 + 4 * s) & 64'hff, "R9");
    end
    @(negedge clk); page_adv = 1; wr_en = 1; wr_idx = 4'd7; wr_data = 16'h4321;
    @(negedge clk); page_adv = 0; wr_en = 0;
    rd_chk(4'd7, 64'h4321, "R9");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule